// File: doc/BRIEF.md
# Low-Order Interleaved Memory Controller

This block sits between a processor's memory address and memory buffer registers and a memory split into sixteen banks. It takes one read or one write at a time from the processor, latches the address into its address register and, for a write, the store data into its buffer register. It then enables exactly one bank, chosen by the lowest address bits, so that consecutive word addresses fall in different banks. The remaining upper address bits and the transfer direction are sent to every bank at once. Only the addressed bank receives a chip select; the others stay idle.

The chip select stays on until the addressed bank reports ready. On a read the controller then copies that bank's data into the buffer register, which is what the processor sees on its read data port. A one-cycle completion pulse follows. A request that asks for a read and a write in the same cycle is refused with a one-cycle error pulse. The default build has a 26-bit word address space, sixteen banks and 32-bit data.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset every chip select is low, and done, busy, error and the read data port are all zero.
- R2: During an access exactly one chip select is high: bit number `cpu_addr[3:0]` of the address that was latched. Address n and n+1 therefore select different banks.
- R3: While no access is in progress (busy low), every chip select is low.
- R4: During an access `bank_row` equals latched address bits 25..4, and `bank_we` is 1 for a write and 0 for a read. Both hold steady until the access ends.
- R5: During a write access `bank_wdata` equals the `cpu_wdata` value that was present on the request cycle.
- R6: A read completes with `cpu_rdata` equal to the data word of the selected bank only. Bank b's word sits at bits b*32+31..b*32 of `bank_rdata`.
- R7: The chip select stays high until the selected bank's ready bit is high at a clock edge. Ready bits of the other banks have no effect.
- R8: `cpu_done` rises in the cycle after the selected bank's ready is sampled, lasts exactly one cycle, and busy and the chip select drop at the same time.
- R9: A request with `cpu_rd` and `cpu_wr` both high while idle starts no access and raises `cpu_err` for exactly one cycle.
- R10: Requests presented while busy are ignored. No second access follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 26 | Word address, latched on request |
| cpu_wdata | input | 32 | Store data, latched on a write request |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_rdata | output | 32 | Buffer register contents |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | One-cycle pulse on an illegal request |
| bank_cs | output | 16 | One-hot bank chip selects |
| bank_row | output | 22 | Upper address bits, sent to every bank |
| bank_we | output | 1 | Direction, sent to every bank (1 = write) |
| bank_wdata | output | 32 | Write data, sent to every bank |
| bank_rdata | input | 512 | Read data from all banks, bank b at slice b |
| bank_rdy | input | 16 | Per-bank ready |

## Verification
The sweep issues reads and writes to every bank. Each bank returns a word that encodes its own number, so a multiplexer that picks a neighbour is caught. Row values include all zeros, all ones and mixed patterns, which separates row broadcast faults from bank decode faults. The ready latency varies from zero to three cycles, and during the wait the neighbouring bank raises a false ready; this tells a correct hold of the chip select apart from one that ends early or follows the wrong bank. Requests presented mid-access and requests with both directions set confirm that neither starts a transfer.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACCESS = 1'b1
   } ilv_state_e;
endpackage

// File: rtl/ilv_bank_decoder.sv
module ilv_bank_decoder #(
   parameter int SEL_W = 4,
   localparam int NB   = 1 << SEL_W
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [NB-1:0]    onehot
);
   genvar gi;
   generate
      for (gi = 0; gi < NB; gi++) begin : g_line
         assign onehot[gi] = en && (sel == SEL_W'(gi));
      end
   endgenerate
endmodule

// File: rtl/ilv_read_mux.sv
module ilv_read_mux #(
   parameter int SEL_W  = 4,
   parameter int DATA_W = 32,
   parameter bit AND_OR = 1'b1,
   localparam int NB    = 1 << SEL_W
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic [NB*DATA_W-1:0] din,
   output logic [DATA_W-1:0]    dout
);
   generate
      if (AND_OR) begin : g_andor
         logic [NB-1:0] line;
         ilv_bank_decoder #(.SEL_W(SEL_W)) dec_i (
            .en     (1'b1),
            .sel    (sel),
            .onehot (line)
         );
         always_comb begin
            dout = '0;
            for (int i = 0; i < NB; i++) begin
               dout = dout | (din[i*DATA_W +: DATA_W] & {DATA_W{line[i]}});
            end
         end
      end else begin : g_index
         assign dout = din[sel*DATA_W +: DATA_W];
      end
   endgenerate
endmodule

// File: rtl/ilv_seq_ctrl.sv
module ilv_seq_ctrl
   import ilv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_rd,
   input  logic req_wr,
   input  logic sel_rdy,
   output logic accept,
   output logic busy,
   output logic dir_wr,
   output logic capture,
   output logic done,
   output logic err
);
   ilv_state_e state_q;
   logic       dir_q;

   assign busy    = (state_q == ST_ACCESS);
   assign accept  = (state_q == ST_IDLE) && (req_rd ^ req_wr);
   assign dir_wr  = dir_q;
   assign capture = busy && sel_rdy && !dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         done <= busy && sel_rdy;
         err  <= (state_q == ST_IDLE) && req_rd && req_wr;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_ACCESS;
                  dir_q   <= req_wr;
               end
            end
            ST_ACCESS: begin
               if (sel_rdy) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
   parameter int ADDR_W     = 26,
   parameter int BANK_SEL_W = 4,
   parameter int DATA_W     = 32,
   parameter bit MUX_AND_OR = 1'b1,
   localparam int NUM_BANKS = 1 << BANK_SEL_W,
   localparam int ROW_W     = ADDR_W - BANK_SEL_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           cpu_addr,
   input  logic [DATA_W-1:0]           cpu_wdata,
   input  logic                        cpu_rd,
   input  logic                        cpu_wr,
   output logic [DATA_W-1:0]           cpu_rdata,
   output logic                        cpu_busy,
   output logic                        cpu_done,
   output logic                        cpu_err,
   output logic [NUM_BANKS-1:0]        bank_cs,
   output logic [ROW_W-1:0]            bank_row,
   output logic                        bank_we,
   output logic [DATA_W-1:0]           bank_wdata,
   input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
   input  logic [NUM_BANKS-1:0]        bank_rdy
);
   generate
      if (BANK_SEL_W < 1 || BANK_SEL_W > 8) begin : g_bad_sel
         $error("BANK_SEL_W must be 1..8");
      end
      if (ADDR_W <= BANK_SEL_W) begin : g_bad_addr
         $error("ADDR_W must exceed BANK_SEL_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [ADDR_W-1:0]     mar_q;
   logic [DATA_W-1:0]     mbr_q;
   logic [BANK_SEL_W-1:0] bank_idx;
   logic [DATA_W-1:0]     mux_out;
   logic                  sel_rdy;
   logic                  accept;
   logic                  busy;
   logic                  dir_wr;
   logic                  capture;

   assign bank_idx = mar_q[BANK_SEL_W-1:0];
   assign sel_rdy  = bank_rdy[bank_idx];

   ilv_seq_ctrl seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_rd  (cpu_rd),
      .req_wr  (cpu_wr),
      .sel_rdy (sel_rdy),
      .accept  (accept),
      .busy    (busy),
      .dir_wr  (dir_wr),
      .capture (capture),
      .done    (cpu_done),
      .err     (cpu_err)
   );

   ilv_bank_decoder #(.SEL_W(BANK_SEL_W)) dec_i (
      .en     (busy),
      .sel    (bank_idx),
      .onehot (bank_cs)
   );

   ilv_read_mux #(
      .SEL_W  (BANK_SEL_W),
      .DATA_W (DATA_W),
      .AND_OR (MUX_AND_OR)
   ) mux_i (
      .sel  (bank_idx),
      .din  (bank_rdata),
      .dout (mux_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar_q <= '0;
         mbr_q <= '0;
      end else if (accept) begin
         mar_q <= cpu_addr;
         if (cpu_wr) mbr_q <= cpu_wdata;
      end else if (capture) begin
         mbr_q <= mux_out;
      end
   end

   assign bank_row   = mar_q[ADDR_W-1:BANK_SEL_W];
   assign bank_we    = dir_wr;
   assign bank_wdata = mbr_q;
   assign cpu_rdata  = mbr_q;
   assign cpu_busy   = busy;
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
module ilv_mem_ctrl_chk #(
   parameter int NB    = 16,
   parameter int ROW_W = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NB-1:0]    bank_cs,
   input logic [NB-1:0]    bank_rdy,
   input logic [ROW_W-1:0] bank_row,
   input logic             bank_we,
   input logic             cpu_busy,
   input logic             cpu_done,
   input logic             cpu_err
);
   p_onehot_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_busy |-> $onehot0(bank_cs) && (|bank_cs));

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> (bank_cs == '0));

   p_row_dir_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(bank_cs & ~bank_rdy)) |=> $stable(bank_row) && $stable(bank_we));

   p_cs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(bank_cs & ~bank_rdy)) |=> (bank_cs == $past(bank_cs)));

   p_done_follows_rdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(bank_cs & bank_rdy)) |=> cpu_done && !cpu_busy);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   p_err_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |-> !cpu_busy && (bank_cs == '0));

   p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |=> !cpu_err);
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
   .NB    (NUM_BANKS),
   .ROW_W (ROW_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bank_cs  (bank_cs),
   .bank_rdy (bank_rdy),
   .bank_row (bank_row),
   .bank_we  (bank_we),
   .cpu_busy (cpu_busy),
   .cpu_done (cpu_done),
   .cpu_err  (cpu_err)
);

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;
   localparam int AW = 26;
   localparam int DW = 32;
   localparam int NB = 16;
   localparam int RW = AW - 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_rd = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_busy, cpu_done, cpu_err;
   logic [NB-1:0] bank_cs;
   logic [RW-1:0] bank_row;
   logic          bank_we;
   logic [DW-1:0] bank_wdata;
   logic [NB*DW-1:0] bank_rdata;
   logic [NB-1:0] bank_rdy = '0;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ilv_mem_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_err(cpu_err),
      .bank_cs(bank_cs), .bank_row(bank_row), .bank_we(bank_we),
      .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .bank_rdy(bank_rdy)
   );

   function automatic logic [DW-1:0] bank_word(int b, logic [RW-1:0] row);
      return {4'(b), 6'h2A, row};
   endfunction

   always_comb begin
      for (int b = 0; b < NB; b++) bank_rdata[b*DW +: DW] = bank_word(b, bank_row);
   end

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic access(bit is_wr, logic [AW-1:0] addr, logic [DW-1:0] wd, int lat, bit poke);
      int b;
      logic [NB-1:0] exp_cs;
      b = int'(addr[3:0]);
      exp_cs = NB'(1) << b;
      @(negedge clk);
      check(bank_cs == '0, "R3 idle cs", 64'(bank_cs), 64'h0);
      cpu_addr = addr; cpu_wdata = wd; cpu_rd = !is_wr; cpu_wr = is_wr;
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = ~wd;
      check(bank_cs == exp_cs, "R2 cs", 64'(bank_cs), 64'(exp_cs));
      check(bank_row == addr[AW-1:4], "R4 row", 64'(bank_row), 64'(addr[AW-1:4]));
      check(bank_we == is_wr, "R4 we", 64'(bank_we), 64'(is_wr));
      if (is_wr) check(bank_wdata == wd, "R5 wdata", 64'(bank_wdata), 64'(wd));
      for (int k = 0; k < lat; k++) begin
         bank_rdy = NB'(1) << (b ^ 1);
         if (poke && k == 0) begin
            cpu_rd = 1'b1; cpu_addr = addr ^ 26'h2;
         end
         @(negedge clk);
         cpu_rd = 1'b0;
         check(bank_cs == exp_cs, "R7 hold cs", 64'(bank_cs), 64'(exp_cs));
         check(cpu_done == 1'b0, "R7 no early done", 64'(cpu_done), 64'h0);
      end
      bank_rdy = exp_cs;
      @(negedge clk);
      bank_rdy = '0;
      check(cpu_done == 1'b1, "R8 done", 64'(cpu_done), 64'h1);
      check(cpu_busy == 1'b0 && bank_cs == '0, "R8 release",
            64'({cpu_busy, bank_cs}), 64'h0);
      if (!is_wr)
         check(cpu_rdata == bank_word(b, addr[AW-1:4]), "R6 rdata",
               64'(cpu_rdata), 64'(bank_word(b, addr[AW-1:4])));
      @(negedge clk);
      check(cpu_done == 1'b0, "R8 pulse width", 64'(cpu_done), 64'h0);
      if (poke)
         check(bank_cs == '0 && !cpu_busy, "R10 busy request ignored",
               64'({cpu_busy, bank_cs}), 64'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      logic [RW-1:0] row;
      repeat (3) @(negedge clk);
      check({bank_cs, cpu_done, cpu_busy, cpu_err} == '0, "R1 reset ctl",
            64'({bank_cs, cpu_done, cpu_busy, cpu_err}), 64'h0);
      check(cpu_rdata == '0, "R1 reset rdata", 64'(cpu_rdata), 64'h0);
      rst_n = 1'b1;
      for (int b = 0; b < NB; b++) begin
         for (int k = 0; k < 3; k++) begin
            row = (k == 0) ? '0 : (k == 1) ? '1 : RW'(32'h15A3C7 * (b + 1));
            access(1'b1, {row, 4'(b)}, 32'hC0DE0000 + 32'(b * 37 + k), (b + k) % 4, 1'b0);
            access(1'b0, {row, 4'(b)}, 32'h0, (b + 2 * k) % 4, (k == 2));
         end
      end
      // R2: consecutive addresses hit consecutive banks
      for (int a = 0; a < 4; a++) access(1'b0, AW'(32'h0123_4560 + a), 32'h0, 1, 1'b0);
      // R9: both directions at once
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         cpu_addr = AW'(k * 5); cpu_rd = 1'b1; cpu_wr = 1'b1;
         @(negedge clk);
         cpu_rd = 1'b0; cpu_wr = 1'b0;
         check(cpu_err == 1'b1, "R9 err", 64'(cpu_err), 64'h1);
         check(bank_cs == '0 && !cpu_busy, "R9 no access",
               64'({cpu_busy, bank_cs}), 64'h0);
         @(negedge clk);
         check(cpu_err == 1'b0, "R9 err width", 64'(cpu_err), 64'h0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule